// File: doc/BRIEF.md
# Pipelined Ripple-Carry Adder

This block adds two unsigned operands of `W` bits (3 by default) and presents a sum that is one bit wider, the top bit being the carry out of the highest position. The carry chain is cut into one full-adder slice per bit position. A bank of registers sits in front of each slice, and all of them load on the falling edge of the shared clock. A fresh operand pair can therefore enter on every falling edge. Each sum leaves the last register bank a fixed number of edges later.

The first register bank takes both operands and a carry-in of zero. Each following bank holds three things: the sum bits already resolved, the carry into the next position, and the operand bits not yet added. The slice for the highest bit is fed from the last bank and drives the two upper result bits directly, without a register. The lower result bits come straight from that bank. While the pipeline fills after reset, the output reads zero.

Top module: `pipe_ripple_adder`

## Requirements
- R1: For every operand pair, the result equals the full unsigned sum `a_i + b_i` in `W+1` bits. Bit `W` is the final carry, so with W = 3 the largest result is 1110 (7 + 7).
- R2: After the reset is released, `z_o` reads all zeros until the first operand pair captured after release has reached the output.
- R3: A pair captured on falling edge n appears on `z_o` right after falling edge n+W-1. It holds until the next falling edge, so a new pair is accepted on every falling edge.
- R4: `rst_i` is active high and is sampled on the falling edge. It clears every register bank, so `z_o` is zero right after an edge where it was high.
- R5: Operands are sampled only on the falling edge. Values present on `a_i`/`b_i` at other times within the same period have no effect on any result.
- R6: With W = 3, the pairs (110,101), (011,101), (111,011), (101,110) are applied, followed by zero pairs. After each falling edge, starting from the first, `z_o` reads 0000, 0000, 1011, 1000, 1010, 1011, 0000, 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all register banks load on its falling edge |
| rst_i | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| z_o | output | W+1 | Sum; bit W is the carry out |

## Verification
Operands are tried with a short fixed sequence whose output stream is known. This separates a correct two-stage delay from an output that is off by one stage. All 64 pairs are applied back to back, so any wrong carry between slices, at any position, shows up as a bad sum. Random pairs show that data items in flight do not mix. A reset in the middle of a stream, followed by non-zero pairs, separates a true clear of every bank from a clear of the last bank only. Inputs that change twice within one period show that only the value present at the falling edge counts.

// File: rtl/padd_pkg.sv
package padd_pkg;

  // Width of register bank k in a W-bit pipeline:
  // remaining operand bits of a and b, resolved sum bits, and one carry.
  function automatic int stage_w(input int w, input int k);
    return 2 * (w - k) + k + 1;
  endfunction

  // Bit offset of bank k inside the flat bank bus.
  function automatic int stage_off(input int w, input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += stage_w(w, j);
    return acc;
  endfunction

endpackage

// File: rtl/padd_fa.sv
module padd_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half;

  assign half = a_i ^ b_i;
  assign s_o  = half ^ c_i;
  assign c_o  = (a_i & b_i) | (c_i & half);

endmodule

// File: rtl/padd_reg.sv
module padd_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);

  always_ff @(negedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= d_i;
  end

endmodule

// File: rtl/pipe_ripple_adder.sv
module pipe_ripple_adder
  import padd_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   z_o
);

  localparam int TOT = stage_off(W, W);
  localparam int LO  = stage_off(W, W - 1);
  localparam int LDW = stage_w(W, W - 1);

  // All register banks side by side; bank k layout (msb..lsb):
  // a[W-1:k], b[W-1:k], sum[k-1:0], carry
  logic [TOT-1:0] bank_q;

  for (genvar k = 0; k < W; k++) begin : g_st
    localparam int AW  = W - k;
    localparam int DW  = stage_w(W, k);
    localparam int OFF = stage_off(W, k);
    logic [DW-1:0] d;

    if (k == 0) begin : g_head
      assign d = {a_i, b_i, 1'b0};
    end else begin : g_body
      localparam int PAW  = W - k + 1;
      localparam int PDW  = stage_w(W, k - 1);
      localparam int POFF = stage_off(W, k - 1);
      logic s_bit, c_bit;

      padd_fa u_fa (
        .a_i (bank_q[POFF + PDW - PAW]),
        .b_i (bank_q[POFF + PDW - 2 * PAW]),
        .c_i (bank_q[POFF]),
        .s_o (s_bit),
        .c_o (c_bit)
      );

      if (k == 1) begin : g_first_sum
        assign d = {bank_q[POFF + PDW - 1 -: AW],
                    bank_q[POFF + PDW - 1 - PAW -: AW],
                    s_bit, c_bit};
      end else begin : g_more_sum
        assign d = {bank_q[POFF + PDW - 1 -: AW],
                    bank_q[POFF + PDW - 1 - PAW -: AW],
                    s_bit, bank_q[POFF + k - 1 : POFF + 1], c_bit};
      end
    end

    padd_reg #(.DW(DW)) u_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (d),
      .q_o   (bank_q[OFF +: DW])
    );
  end

  // Top slice: combinational from the last bank.
  logic top_s, top_c;

  padd_fa u_fa_top (
    .a_i (bank_q[LO + LDW - 1]),
    .b_i (bank_q[LO + LDW - 2]),
    .c_i (bank_q[LO]),
    .s_o (top_s),
    .c_o (top_c)
  );

  assign z_o = {top_c, top_s, bank_q[LO + W - 1 : LO + 1]};

endmodule

// File: rtl/pipe_ripple_adder_chk.sv
module pipe_ripple_adder_chk #(
  parameter int W = 3
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W:0]   z_o
);

  localparam int ZW = W + 1;
  localparam logic [W:0] MAX_SUM = ZW'(2 * ((1 << W) - 1));

  logic [W:0]  exp_sh [W];
  int unsigned fill;

  // Counter-based window and delay line; no parameter-deep $past.
  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      fill <= 0;
      for (int i = 0; i < W; i++) exp_sh[i] <= '0;
    end else begin
      if (fill < W) fill <= fill + 1;
      exp_sh[0] <= ZW'(a_i) + ZW'(b_i);
      for (int i = 1; i < W; i++) exp_sh[i] <= exp_sh[i-1];
    end
  end

  p_sum_r3: assert property (@(negedge clk_i) disable iff (rst_i)
    (fill == W) |-> (z_o == exp_sh[W-1]));

  p_fill_zero_r2: assert property (@(negedge clk_i) disable iff (rst_i)
    (fill < W) |-> (z_o == '0));

  p_reset_clear_r4: assert property (@(negedge clk_i)
    rst_i |=> (z_o == '0));

  p_range_r1: assert property (@(negedge clk_i) disable iff (rst_i)
    (fill == W) |-> (z_o <= MAX_SUM));

endmodule

bind pipe_ripple_adder pipe_ripple_adder_chk #(.W(W)) u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .z_o   (z_o)
);

// File: tb/pipe_ripple_adder_bench.sv
`timescale 1ns/1ps
module pipe_ripple_adder_bench;

  localparam int W  = 3;
  localparam int ZW = W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a   = '0;
  logic [W-1:0]  b   = '0;
  logic [ZW-1:0] z;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [ZW-1:0] exp_q [$];

  always #10 clk = ~clk;  // 50 MHz

  pipe_ripple_adder #(.W(W)) u_pipe_ripple_adder (
    .clk_i (clk),
    .rst_i (rst),
    .a_i   (a),
    .b_i   (b),
    .z_o   (z)
  );

  task automatic chk(input string req, input logic [ZW-1:0] act, input logic [ZW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z=%b expected %b", req, act, exp);
    end
  endtask

  // Sample at rising edge (mid-period), then drive the next pair.
  task automatic step(input logic [W-1:0] av, input logic [W-1:0] bv, input string req);
    @(posedge clk); #1;
    chk(req, z, exp_q.pop_front());
    a = av; b = bv;
    exp_q.push_back(ZW'(av) + ZW'(bv));
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < W; i++) step('0, '0, req);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    rst = 1'b1; a = '0; b = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R4 reset state", z, '0);
    rst = 1'b0;
    exp_q.delete();
    for (int i = 0; i < W; i++) exp_q.push_back('0);
  endtask

  task automatic t_known_sequence();
    logic [W-1:0]  sa [8];
    logic [W-1:0]  sb [8];
    logic [ZW-1:0] want [8];
    sa = '{3'b110, 3'b011, 3'b111, 3'b101, 3'b000, 3'b000, 3'b000, 3'b000};
    sb = '{3'b101, 3'b101, 3'b011, 3'b110, 3'b000, 3'b000, 3'b000, 3'b000};
    want = '{4'b0000, 4'b0000, 4'b1011, 4'b1000, 4'b1010, 4'b1011, 4'b0000, 4'b0000};
    t_reset();
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      if (i > 0) chk("R6 known sequence", z, want[i-1]);
      a = sa[i]; b = sb[i];
    end
    @(posedge clk); #1;
    chk("R6 known sequence", z, want[7]);
  endtask

  task automatic t_exhaustive();
    t_reset();
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        step(W'(i), W'(j), "R1 exhaustive sum");
    drain("R3 exhaustive drain");
  endtask

  task automatic t_carry_extremes();
    t_reset();
    step('1, '1, "R1 max carry");
    step('1, W'(1), "R1 full ripple");
    step('0, '0, "R1 zero");
    step(W'(1), '1, "R1 full ripple");
    drain("R1 max carry 1110 and ripples");
  endtask

  task automatic t_random();
    t_reset();
    for (int i = 0; i < 300; i++)
      step(W'($urandom), W'($urandom), "R3 back-to-back random");
    drain("R3 random drain");
  endtask

  task automatic t_mid_reset();
    t_reset();
    for (int i = 0; i < 5; i++) step(W'(i + 3), '1, "R3 before reset");
    t_reset();
    // Fill: non-zero pairs enter, output must stay zero for W samples.
    for (int i = 0; i < W; i++) step('1, W'(i + 1), "R2 fill zeros after reset");
    drain("R4 post-reset data");
  endtask

  task automatic t_between_edges();
    t_reset();
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] av, bv;
      av = W'($urandom); bv = W'($urandom);
      @(posedge clk); #1;
      chk("R5 only falling-edge value counts", z, exp_q.pop_front());
      a = ~av; b = ~bv;
      #4;
      a = av; b = bv;
      exp_q.push_back(ZW'(av) + ZW'(bv));
      #10;  // after the falling edge: disturb again, must be ignored
      a = '1; b = '1;
    end
    @(posedge clk); #1;
    a = '0; b = '0;
    chk("R5 only falling-edge value counts", z, exp_q.pop_front());
    exp_q.push_back('0);
    drain("R5 drain");
  endtask

  initial begin
    t_reset();
    t_known_sequence();
    t_carry_extremes();
    t_exhaustive();
    t_random();
    t_mid_reset();
    t_between_edges();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule